// File: doc/BRIEF.md
# Serial Link Codec Input Frame Assembler

This block sits on the codec side of a 48 kHz-style serial audio link. Each time the frame sync input rises, it assembles one complete 256-bit input frame and shifts it out MSB first on the bit clock. The frame has a 16-bit tag slot followed by twelve 20-bit data slots. The tag tells the controller whether the codec is ready and which data slots carry meaningful contents.

The frame carries three kinds of content. A register read request that arrives during one frame is answered in the next frame: the echoed address goes in slot 1 and the data fetched through a simple read port goes in slot 2. Six capture samples are packed into slots 3 to 8, and each carries its own valid flag. Slot 12 reports the two GPIO levels and a sticky interrupt flag. That flag is raised when an enabled input pin changes between frame starts, and it stays raised until software writes zero to the pin's status bit.

Top module: `aclink_in_frame`

## Requirements
- R1: After reset `ser_out` is 0. On the first `bit_clk` rising edge that samples `sync` high after it was low, the frame is loaded, and its 256 bits then appear MSB first, one per clock. `ser_out` is 0 once the frame has finished.
- R2: Tag bit 15 (frame bit 255) equals `codec_ready` as sampled at the load edge. Tag bit 15-s is the valid flag of slot s (s = 1..12). Tag bits 2:0 are 0. While `codec_ready` is low, every tag bit is 0.
- R3: A read request (`rd_req` high for one clock, address `rd_addr`) is answered in the next loaded frame. Slot 1 carries the address in bits 18:12 and 0 in all other bits. Slot 2 carries `reg_data` for that address in bits 19:4 and 0 in bits 3:0. Valid bits for slots 1 and 2 are set only in that frame. In frames without a response, slots 1 and 2 are all zero.
- R4: A read request sampled on the same edge as a frame load is answered in the frame after that one, not in the frame being loaded.
- R5: Capture slot 3+i (i = 0..5) carries sample i of `cap_data` (bits i*18 upward) in slot bits 19:2, with bits 1:0 equal to 0. Its tag valid bit (tag bit 12-i) equals `cap_valid[i]` while the codec is ready.
- R6: In slot 12, bit 4 reports GPIO pin 0 and bit 5 reports GPIO pin 1. For a pin configured as input (`gpio_dir` bit = 0), the reported value is the pin level at the load edge. Slot 12 bits 19:6 and 3:1 are 0. Slot 12 is marked valid (tag bit 3) in every frame while ready.
- R7: For a pin configured as output (`gpio_dir` bit = 1), slot 12 reports the `gpio_ctl` bit captured at the previous frame load. It reports 0 if there was no previous frame since reset.
- R8: Slot 12 bit 0 is set when an input pin with its `wake_en` bit set has a different level from the one it had at the previous frame load. The flag shows in the frame in which the change is detected. No event is detected at the first frame after reset, or on a pin with `wake_en` = 0.
- R9: Each pin's interrupt flag is sticky. A `gst_wr` pulse with `gst_wdata` bit = 0 clears that pin's flag, and a written 1 has no effect. Slot 12 bit 0 is the OR of the per-pin flags.
- R10: Slots 9, 10 and 11 are always all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Frame sync; rising edge starts a frame |
| ser_out | output | 1 | Serial input-frame data, MSB first |
| codec_ready | input | 1 | Codec ready indication for tag bit 15 |
| rd_req | input | 1 | One-cycle register read request |
| rd_addr | input | 7 | Address of the read request |
| reg_addr | output | 7 | Address presented to the register read port |
| reg_data | input | 16 | Register read data for `reg_addr` |
| cap_valid | input | 6 | Per-sample capture valid flags |
| cap_data | input | 108 | Six 18-bit two's-complement capture samples |
| gpio_pin | input | 2 | GPIO pin levels |
| gpio_dir | input | 2 | GPIO direction, 1 = output |
| gpio_ctl | input | 2 | GPIO output control bits from the outgoing frame |
| wake_en | input | 2 | Per-pin interrupt enable |
| gst_wr | input | 1 | GPIO status write strobe |
| gst_wdata | input | 2 | GPIO status write data; 0 clears a pin's flag |

## Verification
A stale pending-read register shows up as address and data echoed one frame too early, too late or twice. Any of these is visible in slot 1, slot 2 and tag bits 14:13 within a single frame. A wrong previous-level or previous-control register corrupts slot 12 bits 5:4 or bit 0 in the very next frame. A lost or over-eager sticky flag appears at bit 0 of slot 12 in the first frame after the write. Shift-counter faults misplace every field, or leave nonzero bits on the line after bit 256.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
    localparam int TAG_W    = 16;
    localparam int SLOT_W   = 20;
    localparam int NSLOT    = 12;
    localparam int NCAP     = 6;
    localparam int SAMPLE_W = 18;
    localparam int NGPIO    = 2;
    localparam int ADDR_W   = 7;
    localparam int DATA_W   = 16;
    localparam int FRAME_W  = TAG_W + NSLOT * SLOT_W;
    localparam int CAP_SLOT0 = 3;
    localparam int GPIO_SLOT = 12;
    localparam int GPIO_LSB  = 4;
    localparam int ADDR_LSB  = 12;
endpackage

// File: rtl/aclink_shift.sv
module aclink_shift
    import aclink_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync,
    input  logic [W-1:0] frame_in,
    output logic         load,
    output logic         sdata
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             sync_prev;
        logic [W-1:0]     sh;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign load  = sync & ~st_q.sync_prev;
    assign sdata = st_q.sh[W-1];

    always_comb begin
        st_d = st_q;
        st_d.sync_prev = sync;
        if (load) begin
            st_d.sh  = frame_in;
            st_d.cnt = CNT_W'(W);
        end else if (st_q.cnt != '0) begin
            st_d.sh  = {st_q.sh[W-2:0], 1'b0};
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0) |-> !sdata);
endmodule

// File: rtl/aclink_rdresp.sv
module aclink_rdresp
    import aclink_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          rd_req,
    input  logic [AW-1:0] rd_addr,
    output logic          resp_v,
    output logic [AW-1:0] resp_addr
);
    typedef struct packed {
        logic          pend;
        logic [AW-1:0] addr;
    } st_t;

    st_t st_d, st_q;

    assign resp_v    = st_q.pend;
    assign resp_addr = st_q.addr;

    always_comb begin
        st_d = st_q;
        if (load)   st_d.pend = 1'b0;
        if (rd_req) begin
            st_d.pend = 1'b1;
            st_d.addr = rd_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    resp_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !rd_req) |=> !resp_v);
    // R4
    late_req_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && rd_req) |=> (resp_v && resp_addr == $past(rd_addr)));
endmodule

// File: rtl/aclink_gpio.sv
module aclink_gpio
    import aclink_pkg::*;
#(
    parameter int N = NGPIO
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] pin,
    input  logic [N-1:0] dir,
    input  logic [N-1:0] ctl,
    input  logic [N-1:0] wen,
    input  logic         wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] level,
    output logic         irq_flag
);
    typedef struct packed {
        logic         primed;
        logic [N-1:0] pin_prev;
        logic [N-1:0] ctl_prev;
        logic [N-1:0] irq;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] evt;

    always_comb begin
        evt      = st_q.primed ? ((pin ^ st_q.pin_prev) & ~dir & wen) : '0;
        level    = (dir & st_q.ctl_prev) | (~dir & pin);
        irq_flag = |(st_q.irq | evt);
        st_d = st_q;
        if (wr) st_d.irq = st_q.irq & wdata;
        if (load) begin
            st_d.irq      = st_d.irq | evt;
            st_d.pin_prev = pin;
            st_d.ctl_prev = ctl;
            st_d.primed   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9
        irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.irq[i] && !(wr && !wdata[i])) |=> st_q.irq[i]);
        // R8
        irq_at_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(st_q.irq[i]) |-> $past(load));
    end
endmodule

// File: rtl/aclink_in_frame.sv
module aclink_in_frame
    import aclink_pkg::*;
(
    input  logic                     bit_clk,
    input  logic                     rst_n,
    input  logic                     sync,
    output logic                     ser_out,
    input  logic                     codec_ready,
    input  logic                     rd_req,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_data,
    input  logic [NCAP-1:0]          cap_valid,
    input  logic [NCAP*SAMPLE_W-1:0] cap_data,
    input  logic [NGPIO-1:0]         gpio_pin,
    input  logic [NGPIO-1:0]         gpio_dir,
    input  logic [NGPIO-1:0]         gpio_ctl,
    input  logic [NGPIO-1:0]         wake_en,
    input  logic                     gst_wr,
    input  logic [NGPIO-1:0]         gst_wdata
);
    localparam int TAG_TOP = FRAME_W - 1;

    logic               load;
    logic               resp_v;
    logic [NGPIO-1:0]   gpio_level;
    logic               irq_flag;
    logic [FRAME_W-1:0] frame_d;

    function automatic int slot_lo(input int s);
        return FRAME_W - TAG_W - SLOT_W * s;
    endfunction

    aclink_shift #(.W(FRAME_W)) u_shift (
        .clk(bit_clk), .rst_n(rst_n), .sync(sync),
        .frame_in(frame_d), .load(load), .sdata(ser_out)
    );

    aclink_rdresp #(.AW(ADDR_W)) u_rd (
        .clk(bit_clk), .rst_n(rst_n), .load(load),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .resp_v(resp_v), .resp_addr(reg_addr)
    );

    aclink_gpio #(.N(NGPIO)) u_gpio (
        .clk(bit_clk), .rst_n(rst_n), .load(load),
        .pin(gpio_pin), .dir(gpio_dir), .ctl(gpio_ctl), .wen(wake_en),
        .wr(gst_wr), .wdata(gst_wdata),
        .level(gpio_level), .irq_flag(irq_flag)
    );

    always_comb begin
        frame_d = '0;
        frame_d[TAG_TOP] = codec_ready;
        if (codec_ready) begin
            frame_d[TAG_TOP-1] = resp_v;
            frame_d[TAG_TOP-2] = resp_v;
            for (int i = 0; i < NCAP; i++)
                frame_d[TAG_TOP-CAP_SLOT0-i] = cap_valid[i];
            frame_d[TAG_TOP-GPIO_SLOT] = 1'b1;
        end
        if (resp_v) begin
            frame_d[slot_lo(1)+ADDR_LSB +: ADDR_W]      = reg_addr;
            frame_d[slot_lo(2)+SLOT_W-DATA_W +: DATA_W] = reg_data;
        end
        for (int i = 0; i < NCAP; i++)
            frame_d[slot_lo(CAP_SLOT0+i)+SLOT_W-SAMPLE_W +: SAMPLE_W] =
                cap_data[i*SAMPLE_W +: SAMPLE_W];
        frame_d[slot_lo(GPIO_SLOT)+GPIO_LSB +: NGPIO] = gpio_level;
        frame_d[slot_lo(GPIO_SLOT)]                   = irq_flag;
    end

    // R2
    tag_ready_chk: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> (ser_out == $past(codec_ready)));
endmodule

// File: tb/sim_aclink_in_frame.sv
module sim_aclink_in_frame;
    localparam int CLK_PERIOD = 10;

    logic         bit_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sync = 1'b0;
    logic         ser_out;
    logic         codec_ready = 1'b0;
    logic         rd_req = 1'b0;
    logic [6:0]   rd_addr = '0;
    logic [6:0]   reg_addr;
    logic [15:0]  reg_data;
    logic [5:0]   cap_valid = '0;
    logic [107:0] cap_data = '0;
    logic [1:0]   gpio_pin = '0, gpio_dir = '0, gpio_ctl = '0, wake_en = '0;
    logic         gst_wr = 1'b0;
    logic [1:0]   gst_wdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    logic [255:0] exp_q[$];
    string        note_q[$];
    int           n_seen = 0;

    // model state
    logic       m_pend = 1'b0;
    logic [6:0] m_addr = '0;
    logic       m_primed = 1'b0;
    logic [1:0] m_ppin = '0, m_pctl = '0, m_irq = '0;

    always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

    function automatic logic [15:0] reg_fn(input logic [6:0] a);
        return 16'hA500 ^ {9'b0, a};
    endfunction
    assign reg_data = reg_fn(reg_addr);

    aclink_in_frame u0 (
        .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync), .ser_out(ser_out),
        .codec_ready(codec_ready), .rd_req(rd_req), .rd_addr(rd_addr),
        .reg_addr(reg_addr), .reg_data(reg_data),
        .cap_valid(cap_valid), .cap_data(cap_data),
        .gpio_pin(gpio_pin), .gpio_dir(gpio_dir), .gpio_ctl(gpio_ctl),
        .wake_en(wake_en), .gst_wr(gst_wr), .gst_wdata(gst_wdata)
    );

    task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // expected frame from requirement field positions
    function automatic logic [255:0] build_exp();
        logic [255:0] f = '0;
        logic [1:0] evt, lvl;
        evt = m_primed ? ((gpio_pin ^ m_ppin) & ~gpio_dir & wake_en) : 2'b00;
        lvl = (gpio_dir & m_pctl) | (~gpio_dir & gpio_pin);
        f[255] = codec_ready;                                   // R2
        if (codec_ready) begin
            f[254] = m_pend; f[253] = m_pend;                   // R3
            for (int i = 0; i < 6; i++) f[252-i] = cap_valid[i]; // R5
            f[243] = 1'b1;                                      // R6
        end
        if (m_pend) begin
            f[220+12 +: 7]  = m_addr;
            f[200+4 +: 16]  = reg_fn(m_addr);
        end
        for (int i = 0; i < 6; i++)
            f[240-20*(3+i)+2 +: 18] = cap_data[i*18 +: 18];
        f[4 +: 2] = lvl;                                        // R6 R7
        f[0] = |(m_irq | evt);                                  // R8 R9
        return f;
    endfunction

    task automatic model_load();
        logic [1:0] evt;
        evt = m_primed ? ((gpio_pin ^ m_ppin) & ~gpio_dir & wake_en) : 2'b00;
        m_irq = m_irq | evt;
        m_pend = 1'b0;
        m_ppin = gpio_pin; m_pctl = gpio_ctl; m_primed = 1'b1;
    endtask

    // driver: pushes the expected frame, then pulses sync
    task automatic send_frame(input string note, input bit with_read = 0, input logic [6:0] a = '0);
        exp_q.push_back(build_exp());
        note_q.push_back(note);
        model_load();
        @(negedge bit_clk);
        sync = 1'b1;
        if (with_read) begin
            rd_req = 1'b1; rd_addr = a;
            m_pend = 1'b1; m_addr = a;   // R4: lands in the following frame
        end
        @(negedge bit_clk);
        sync = 1'b0; rd_req = 1'b0;
        repeat (262) @(negedge bit_clk);
    endtask

    task automatic issue_read(input logic [6:0] a);
        @(negedge bit_clk);
        rd_req = 1'b1; rd_addr = a;
        @(negedge bit_clk);
        rd_req = 1'b0;
        m_pend = 1'b1; m_addr = a;
    endtask

    task automatic status_write(input logic [1:0] d);
        @(negedge bit_clk);
        gst_wr = 1'b1; gst_wdata = d;
        @(negedge bit_clk);
        gst_wr = 1'b0;
        m_irq = m_irq & d;
    endtask

    // monitor: collects each serial frame and compares field by field
    initial begin
        forever begin
            logic [255:0] got, exp;
            string nt;
            @(posedge sync);
            @(posedge bit_clk);
            for (int b = 255; b >= 0; b--) begin
                @(negedge bit_clk);
                got[b] = ser_out;
            end
            @(negedge bit_clk);
            exp = exp_q.pop_front();
            nt  = note_q.pop_front();
            n_seen++;
            check({"R1 trailing zero ", nt}, {255'b0, ser_out}, '0);
            check({"R2 tag ", nt},          {240'b0, got[255:240]}, {240'b0, exp[255:240]});
            check({"R3 slot1 ", nt},        {236'b0, got[239:220]}, {236'b0, exp[239:220]});
            check({"R3 slot2 ", nt},        {236'b0, got[219:200]}, {236'b0, exp[219:200]});
            check({"R5 capture ", nt},      {136'b0, got[199:80]},  {136'b0, exp[199:80]});
            check({"R10 slots9-11 ", nt},   {196'b0, got[79:20]},   {196'b0, exp[79:20]});
            check({"R6 slot12 ", nt},       {236'b0, got[19:0]},    {236'b0, exp[19:0]});
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge bit_clk);
        check("R1 reset output", {255'b0, ser_out}, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge bit_clk);
        check("R1 idle after reset", {255'b0, ser_out}, '0);

        // not ready: tag all zero, data still packed
        cap_valid = 6'b111111;
        for (int i = 0; i < 6; i++) cap_data[i*18 +: 18] = 18'h20001 + 18'(i * 4097);
        send_frame("R2 not ready");

        // R3 read response and R5 capture flags
        codec_ready = 1'b1;
        issue_read(7'h26);
        cap_valid = 6'b101101;
        gpio_dir = 2'b10; gpio_ctl = 2'b11;
        send_frame("R3 response");

        // R8 event on pin0, R7 readback of ctl
        gpio_pin = 2'b01; wake_en = 2'b01; gpio_ctl = 2'b00;
        cap_data = {18'h3FFFF, 18'h00000, 18'h2AAAA, 18'h15555, 18'h20000, 18'h1FFFF};
        send_frame("R7 R8 pin0 event");
        send_frame("R9 sticky hold");
        status_write(2'b11);
        send_frame("R9 write ones no effect");
        status_write(2'b10);
        gpio_dir = 2'b00; gpio_pin = 2'b11;
        send_frame("R9 clear and masked pin1 change");

        // R4 request at the load edge
        send_frame("R4 request with sync", 1, 7'h7F);
        wake_en = 2'b10; gpio_pin = 2'b01;
        send_frame("R4 late response, R8 pin1 event");
        status_write(2'b10);
        send_frame("R9 other pin clear keeps flag");
        status_write(2'b01);
        cap_valid = 6'b000000;
        send_frame("R9 pin1 cleared");

        repeat (5) @(negedge bit_clk);
        check("R1 frames seen", 256'(n_seen), 256'd10);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule